// File: doc/BRIEF.md
# Register Access Error Interrupt Controller

This block is a small register slave that polices its own address space. It sits on a single-cycle register bus that makes one access per cycle. Read data and the error response come back in the same cycle as the access, and a write takes effect at the clock edge that ends it. Two kinds of bad access are caught. The first is a write to the protected register while the space is locked. The second is any read or write to an address outside the legal map. Every bad access sets a sticky raw flag. The flag sets even when its interrupt is disabled.

Software enables each interrupt by writing ones to a set register, and disables it by writing ones to a separate clear register. A masked view reads as raw AND enable. Writing ones to that view, or to the raw register itself, clears the matching raw flags. A write-error line and a read-error line leave the block. The details of the first bad access are held in three fault registers until software writes the release bit. To unlock the space, two key words must be written in order, one to each of two key registers. Any other write to a key register locks the space again.

Top module: `regerr_ctl`

Register map (word address, the low four bits of `req_addr`):
- 0: key A. Reads bit0 = 1 while unlocked.
- 1: key B. Reads 0.
- 2: raw flags. Bit0 = lock violation, bit1 = address error. Writing 1 clears a flag.
- 3: masked view. Reads raw AND enable. Writing 1 clears the raw flag.
- 4: enable set. Writing 1 sets a bit. Reads the enables.
- 5: enable clear. Writing 1 clears a bit. Reads the enables.
- 6: fault address.
- 7: fault kind.
- 8: fault attributes.
- 9: fault release. Writing bit0 = 1 releases the fault registers. Reads 0.
- 10: protected data register.
- 11 and above: illegal.

## Requirements
- R1: After reset the space is locked, the raw flags, enables and fault registers are 0, and both interrupt lines are low.
- R2: The space unlocks only when key A (32'h5A5A_1234) is written to address 0 and the next key-register write is key B (32'hA5A5_4321) to address 1. Any other write to address 0 or 1 locks the space. Address 0 reads 1 in bit0 while unlocked.
- R3: A write to address 10 while locked does not change that register and sets raw bit0. The same write while unlocked updates the register.
- R4: An access to address 11 or above sets raw bit1. An illegal read returns 0 with `rsp_err` high in that cycle. An illegal write changes no register.
- R5: Raw flags set whether or not the matching enable bit is 1.
- R6: Writing 1 to an enable bit at address 4 sets it, and writing 1 at address 5 clears it. Zero bits written to either address have no effect.
- R7: Address 3 reads raw AND enable. Writing 1 to a bit of address 3 or address 2 clears that raw flag.
- R8: `irq_wr` is high while (raw bit0 AND enable bit0) holds, or while (raw bit1 AND enable bit1) holds and an illegal write has occurred since raw bit1 was last clear. `irq_rd` is high while raw bit1 AND enable bit1 holds and an illegal read has occurred in the same window.
- R9: On the first bad access the fault address, the kind and the attributes are captured. The kind is 1 for a lock violation, 2 for an illegal read and 3 for an illegal write. The attributes are {requester ID, privilege} with privilege in bit0.
- R10: Later bad accesses leave the fault registers unchanged. A write with bit0 = 1 to address 9 zeroes the fault registers and re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access valid this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Privilege attribute of the access |
| req_id | input | ID_W | Requester ID of the access |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Error response for an illegal read, same cycle |
| irq_wr | output | 1 | Write-error interrupt |
| irq_rd | output | 1 | Read-error interrupt |

## Verification
The assertions assume at most one access per cycle and bus inputs that are known whenever `req_vld` is high. The stability checks on the fault registers and the protected register rely on this. The bench drives every access on the falling edge. It holds `req_vld` for exactly one cycle and drops it afterwards, so no access overlaps another and no input changes close to the sampling edge.

// File: rtl/regerr_pkg.sv
package regerr_pkg;
  localparam int unsigned SLOT_W = 4;
  localparam logic [SLOT_W-1:0] S_KEYA   = 4'd0;
  localparam logic [SLOT_W-1:0] S_KEYB   = 4'd1;
  localparam logic [SLOT_W-1:0] S_RAW    = 4'd2;
  localparam logic [SLOT_W-1:0] S_MASKED = 4'd3;
  localparam logic [SLOT_W-1:0] S_ENSET  = 4'd4;
  localparam logic [SLOT_W-1:0] S_ENCLR  = 4'd5;
  localparam logic [SLOT_W-1:0] S_FADDR  = 4'd6;
  localparam logic [SLOT_W-1:0] S_FKIND  = 4'd7;
  localparam logic [SLOT_W-1:0] S_FATTR  = 4'd8;
  localparam logic [SLOT_W-1:0] S_FREL   = 4'd9;
  localparam logic [SLOT_W-1:0] S_DATA   = 4'd10;
  localparam int unsigned NUM_SLOTS = 11;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_LOCK = 2'd1,
    FK_RDIL = 2'd2,
    FK_WRIL = 2'd3
  } fkind_e;

  function automatic logic [1:0] masked_view(input logic [1:0] raw, input logic [1:0] en);
    return raw & en;
  endfunction

  function automatic logic [1:0] raw_next(input logic [1:0] raw, input logic [1:0] clr,
                                          input logic [1:0] set);
    return (raw & ~clr) | set;
  endfunction
endpackage

// File: rtl/regerr_lock.sv
module regerr_lock #(
  parameter logic [31:0] KEY_A = 32'h5A5A_1234,
  parameter logic [31:0] KEY_B = 32'hA5A5_4321
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_keya,
  input  logic        wr_keyb,
  input  logic [31:0] wdata,
  output logic        unlocked
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else if (wr_keya) begin
      armed    <= (wdata == KEY_A);
      unlocked <= 1'b0;
    end else if (wr_keyb) begin
      armed    <= 1'b0;
      unlocked <= armed && (wdata == KEY_B);
    end
  end

  // R2
  unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_keyb && wdata == KEY_B));

  // R2
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_keya |=> !unlocked);
endmodule

// File: rtl/regerr_decode.sv
module regerr_decode
  import regerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              vld,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlocked,
  output logic              legal,
  output logic              wr_ok,
  output logic              ev_lock,
  output logic              ev_rdil,
  output logic              ev_wril
);
  always_comb begin
    legal   = ({{(32-ADDR_W){1'b0}}, addr} < 32'(NUM_SLOTS));
    ev_rdil = vld && !wr && !legal;
    ev_wril = vld &&  wr && !legal;
    ev_lock = vld &&  wr && legal && (addr[SLOT_W-1:0] == S_DATA) && !unlocked;
    wr_ok   = vld &&  wr && legal && !ev_lock;
  end
endmodule

// File: rtl/regerr_fault.sv
module regerr_fault
  import regerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned ATTR_W = ID_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_lock,
  input  logic              ev_rdil,
  input  logic              ev_wril,
  input  logic              release_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic [ID_W-1:0]   id,
  output logic [ADDR_W-1:0] f_addr,
  output fkind_e            f_kind,
  output logic [ATTR_W-1:0] f_attr
);
  logic any_ev, held;
  assign any_ev = ev_lock | ev_rdil | ev_wril;
  assign held   = (f_kind != FK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_addr <= '0;
      f_kind <= FK_NONE;
      f_attr <= '0;
    end else if (release_i) begin
      f_addr <= '0;
      f_kind <= FK_NONE;
      f_attr <= '0;
    end else if (any_ev && !held) begin
      f_addr <= addr;
      f_kind <= ev_lock ? FK_LOCK : (ev_rdil ? FK_RDIL : FK_WRIL);
      f_attr <= {id, priv};
    end
  end

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_i) |=> ($stable(f_addr) && $stable(f_kind) && $stable(f_attr)));

  // R9
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ev && !held && !release_i) |=> (f_kind != FK_NONE));
endmodule

// File: rtl/regerr_ctl.sv
module regerr_ctl
  import regerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned ID_W   = 4,
  parameter logic [31:0] KEY_A  = 32'h5A5A_1234,
  parameter logic [31:0] KEY_B  = 32'hA5A5_4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_priv,
  input  logic [ID_W-1:0]   req_id,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq_wr,
  output logic              irq_rd
);
  localparam int unsigned ATTR_W = ID_W + 1;

  logic              legal, wr_ok, ev_lock, ev_rdil, ev_wril, unlocked;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        raw_q, en_q, raw_set, raw_clr;
  logic              seen_rd, seen_wr;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] f_addr;
  fkind_e            f_kind;
  logic [ATTR_W-1:0] f_attr;
  logic              w_keya, w_keyb, w_rel;

  assign slot   = req_addr[SLOT_W-1:0];
  assign w_keya = wr_ok && slot == S_KEYA;
  assign w_keyb = wr_ok && slot == S_KEYB;
  assign w_rel  = wr_ok && slot == S_FREL && req_wdata[0];

  regerr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .vld(req_vld), .wr(req_wr), .addr(req_addr), .unlocked(unlocked),
    .legal(legal), .wr_ok(wr_ok), .ev_lock(ev_lock), .ev_rdil(ev_rdil), .ev_wril(ev_wril));

  regerr_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_keya(w_keya), .wr_keyb(w_keyb),
    .wdata(req_wdata), .unlocked(unlocked));

  regerr_fault #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .ev_lock(ev_lock), .ev_rdil(ev_rdil), .ev_wril(ev_wril),
    .release_i(w_rel), .addr(req_addr), .priv(req_priv), .id(req_id),
    .f_addr(f_addr), .f_kind(f_kind), .f_attr(f_attr));

  assign raw_set = {ev_rdil | ev_wril, ev_lock};
  assign raw_clr = (wr_ok && (slot == S_RAW || slot == S_MASKED)) ? req_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      seen_rd <= 1'b0;
      seen_wr <= 1'b0;
      data_q  <= '0;
    end else begin
      raw_q <= raw_next(raw_q, raw_clr, raw_set);
      if (raw_clr[1] && !raw_set[1]) begin
        seen_rd <= 1'b0;
        seen_wr <= 1'b0;
      end else begin
        seen_rd <= seen_rd | ev_rdil;
        seen_wr <= seen_wr | ev_wril;
      end
      if (wr_ok && slot == S_ENSET) en_q <= en_q | req_wdata[1:0];
      if (wr_ok && slot == S_ENCLR) en_q <= en_q & ~req_wdata[1:0];
      if (wr_ok && slot == S_DATA)  data_q <= req_wdata;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (req_vld && !req_wr && legal) begin
      unique case (slot)
        S_KEYA:            rsp_rdata = {31'd0, unlocked};
        S_RAW:             rsp_rdata = {30'd0, raw_q};
        S_MASKED:          rsp_rdata = {30'd0, masked_view(raw_q, en_q)};
        S_ENSET, S_ENCLR:  rsp_rdata = {30'd0, en_q};
        S_FADDR:           rsp_rdata = 32'(f_addr);
        S_FKIND:           rsp_rdata = {30'd0, f_kind};
        S_FATTR:           rsp_rdata = 32'(f_attr);
        S_DATA:            rsp_rdata = data_q;
        default:           rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_err = ev_rdil;
  assign irq_wr  = (raw_q[0] & en_q[0]) | (raw_q[1] & en_q[1] & seen_wr);
  assign irq_rd  = raw_q[1] & en_q[1] & seen_rd;

  // R3
  locked_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> ($stable(data_q) && raw_q[0]));

  // R5
  addr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rdil || ev_wril) |=> raw_q[1]);

  // R6
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && slot == S_ENCLR) |=> ((en_q & $past(req_wdata[1:0])) == 2'b00));

  // R8
  irq_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rdil && en_q[1] && !(wr_ok && slot == S_ENCLR) |=> irq_rd);

  // R4
  ill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0));
endmodule

// File: tb/sim_regerr_ctl.sv
module sim_regerr_ctl;
  localparam logic [31:0] KA = 32'h5A5A_1234;
  localparam logic [31:0] KB = 32'hA5A5_4321;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] wd;
    logic [31:0] erd;
    logic        eerr;
    logic        eiw;
    logic        eir;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b1, 4'd10, 32'h11,   32'h0, 1'b0, 1'b0, 1'b0}, // R3 locked write
    '{1'b0, 4'd2,  32'h0,    32'h1, 1'b0, 1'b0, 1'b0}, // R5 raw set while disabled
    '{1'b0, 4'd10, 32'h0,    32'h0, 1'b0, 1'b0, 1'b0}, // R3 unchanged
    '{1'b1, 4'd4,  32'h3,    32'h0, 1'b0, 1'b1, 1'b0}, // R6 enable, R8 irq_wr
    '{1'b0, 4'd3,  32'h0,    32'h1, 1'b0, 1'b1, 1'b0}, // R7 masked view
    '{1'b1, 4'd3,  32'h1,    32'h0, 1'b0, 1'b0, 1'b0}, // R7 clear via masked
    '{1'b0, 4'd12, 32'h0,    32'h0, 1'b1, 1'b0, 1'b1}, // R4 illegal read, R8
    '{1'b0, 4'd7,  32'h0,    32'h1, 1'b0, 1'b0, 1'b1}, // R10 first fault kept
    '{1'b0, 4'd6,  32'h0,    32'hA, 1'b0, 1'b0, 1'b1}, // R9 address
    '{1'b1, 4'd9,  32'h1,    32'h0, 1'b0, 1'b0, 1'b1}, // R10 release
    '{1'b0, 4'd7,  32'h0,    32'h0, 1'b0, 1'b0, 1'b1}, // R10 emptied
    '{1'b1, 4'd13, 32'hFF,   32'h0, 1'b0, 1'b1, 1'b1}, // R4 illegal write, R8
    '{1'b0, 4'd7,  32'h0,    32'h3, 1'b0, 1'b1, 1'b1}, // R9 kind
    '{1'b0, 4'd6,  32'h0,    32'hD, 1'b0, 1'b1, 1'b1}, // R9 address
    '{1'b1, 4'd2,  32'h2,    32'h0, 1'b0, 1'b0, 1'b0}, // R7 clear via raw
    '{1'b1, 4'd5,  32'h1,    32'h0, 1'b0, 1'b0, 1'b0}, // R6 enable clear
    '{1'b0, 4'd4,  32'h0,    32'h2, 1'b0, 1'b0, 1'b0}, // R6 readback
    '{1'b1, 4'd4,  32'h0,    32'h0, 1'b0, 1'b0, 1'b0}, // R6 zero no effect
    '{1'b0, 4'd5,  32'h0,    32'h2, 1'b0, 1'b0, 1'b0}, // R6 readback
    '{1'b1, 4'd0,  KA,       32'h0, 1'b0, 1'b0, 1'b0}, // R2 key A
    '{1'b1, 4'd1,  KB,       32'h0, 1'b0, 1'b0, 1'b0}, // R2 key B
    '{1'b0, 4'd0,  32'h0,    32'h1, 1'b0, 1'b0, 1'b0}, // R2 unlocked
    '{1'b1, 4'd10, 32'h77,   32'h0, 1'b0, 1'b0, 1'b0}, // R3 unlocked write
    '{1'b0, 4'd10, 32'h0,    32'h77,1'b0, 1'b0, 1'b0}  // R3 readback
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_wr = 1'b0, req_priv = 1'b0;
  logic [3:0]  req_addr = '0, req_id = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic        rsp_err, irq_wr, irq_rd;
  int          n_run = 0, n_fail = 0;
  logic [31:0] g_rd;
  logic        g_err;

  always #2.5 clk = ~clk;

  regerr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_id(req_id),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_wr(irq_wr), .irq_rd(irq_rd));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic p, input logic [3:0] id);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_priv = p; req_id = id;
    #1;
    g_rd = rsp_rdata; g_err = rsp_err;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_priv = 1'b0; req_id = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
    acc(1'b0, a, 32'h0, 1'b0, 4'h0);
    chk(tag, g_rd, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_wr reset", {31'd0, irq_wr}, 32'd0);
    chk("R1 irq_rd reset", {31'd0, irq_rd}, 32'd0);
    rst_n = 1'b1;
    rd(4'd0, "R1 locked", 32'd0);
    rd(4'd2, "R1 raw", 32'd0);
    rd(4'd4, "R1 enable", 32'd0);
    rd(4'd7, "R1 fault kind", 32'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VT[i].wr, VT[i].addr, VT[i].wd, 1'b0, 4'h0);
      chk($sformatf("vec%0d rdata", i), g_rd, VT[i].erd);
      chk($sformatf("vec%0d err", i), {31'd0, g_err}, {31'd0, VT[i].eerr});
      chk($sformatf("vec%0d irq_wr", i), {31'd0, irq_wr}, {31'd0, VT[i].eiw});
      chk($sformatf("vec%0d irq_rd", i), {31'd0, irq_rd}, {31'd0, VT[i].eir});
    end

    // R2: a stray key write relocks, and the locked write is dropped again
    acc(1'b1, 4'd1, 32'h0, 1'b0, 4'h0);
    rd(4'd0, "R2 relock", 32'd0);
    acc(1'b1, 4'd10, 32'h99, 1'b0, 4'h0);
    rd(4'd10, "R3 relocked write dropped", 32'h77);
    rd(4'd2, "R5 lock flag set with enable clear", 32'h1);
    chk("R8 no irq while disabled", {30'd0, irq_wr, irq_rd}, 32'd0);
    rd(4'd7, "R10 held kind", 32'h3);

    // R2: keys in the wrong order do not unlock
    acc(1'b1, 4'd1, KB, 1'b0, 4'h0);
    acc(1'b1, 4'd0, KA, 1'b0, 4'h0);
    acc(1'b1, 4'd0, KB, 1'b0, 4'h0);
    acc(1'b1, 4'd1, KB, 1'b0, 4'h0);
    rd(4'd0, "R2 wrong order", 32'd0);

    // R9: attributes {id, priv}
    acc(1'b1, 4'd9, 32'h1, 1'b0, 4'h0);
    acc(1'b0, 4'd15, 32'h0, 1'b1, 4'h5);
    chk("R4 err on read of 15", {31'd0, g_err}, 32'd1);
    rd(4'd8, "R9 attr", 32'hB);
    rd(4'd7, "R9 kind illegal read", 32'h2);
    acc(1'b1, 4'd11, 32'h0, 1'b0, 4'h3);
    rd(4'd6, "R10 addr not overwritten", 32'hF);
    rd(4'd8, "R10 attr not overwritten", 32'hB);

    // R4: an illegal write touches nothing; R7 clearing raw bit1 drops both lines
    acc(1'b1, 4'd4, 32'h3, 1'b0, 4'h0);
    chk("R8 irq_wr on illegal write", {31'd0, irq_wr}, 32'd1);
    chk("R8 irq_rd on illegal read", {31'd0, irq_rd}, 32'd1);
    acc(1'b1, 4'd2, 32'h3, 1'b0, 4'h0);
    chk("R7 lines drop", {30'd0, irq_wr, irq_rd}, 32'd0);
    rd(4'd4, "R4 enables intact", 32'h3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule